// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits in front of a 2048-word by 9-bit memory array that two independent ports share. Each port presents an enable, an 11-bit address, a write strobe, a read (output) enable and write data, and receives read data. When both ports are enabled on the same word in the same cycle, the block lets one of them keep the word. It raises an active-low busy flag toward the other port and masks that port's write, so the array cannot be corrupted by the loser. Reads by the loser still complete.

The arbitration looks only at the enables and the addresses. A port that was already parked on the word in the previous cycle keeps it. If both arrive in the same cycle, the left port wins. The decision is held in a register while the collision lasts, so the winner cannot flip in the middle of a contention.

A mode input selects between two roles. As the deciding device, the block drives its own busy flags. As a follower in a wider array, it generates no busy flags. Each port's external busy input then acts purely as a write inhibit, so several arrays can share one decision made elsewhere.

Top module: `dual_port_arbiter`

## Requirements
- R1: While reset is asserted, and after reset with both ports idle, both busy outputs read 1 (not busy). No winner is carried into the first collision.
- R2: In master mode (slave_mode_i = 0), a busy output is 0 only when both port enables are 1 and both addresses are equal. Whether either port reads or writes does not matter.
- R3: If one port was enabled on the colliding address in the previous cycle and the other was not, the earlier port keeps access. The other port's busy output goes to 0 in the same cycle as the collision.
- R4: In master mode, a collision always gives exactly one busy output at 0. When both ports arrive in the same cycle, the right port receives busy.
- R5: Once a winner is chosen, it stays the winner on every following cycle in which the collision persists.
- R6: The loser's busy output returns to 1 in the same cycle in which the addresses differ or either enable is 0.
- R7: A write by a port whose busy output is 0 in master mode does not modify the array.
- R8: A read by the losing port still returns the array contents.
- R9: In slave mode (slave_mode_i = 1), both busy outputs stay at 1. A port whose busy input is 0 cannot write, and a port whose busy input is 1 writes normally, even on a colliding address.
- R10: Read data appears on the port's rdata output in the cycle after a read with enable and output enable both at 1. It shows the word before any write of that same cycle, and it holds its value while no read is issued.
- R11: In master mode the busy inputs have no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_mode_i | input | 1 | 1: busy pins act as external write inhibits; 0: busy generated internally |
| l_en_i | input | 1 | Left port enable |
| l_wr_i | input | 1 | Left port write strobe |
| l_oe_i | input | 1 | Left port read enable |
| l_addr_i | input | 11 | Left port word address |
| l_wdata_i | input | 9 | Left port write data |
| l_rdata_o | output | 9 | Left port read data, registered |
| l_busy_n_i | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n_o | output | 1 | Left busy flag, active low |
| r_en_i | input | 1 | Right port enable |
| r_wr_i | input | 1 | Right port write strobe |
| r_oe_i | input | 1 | Right port read enable |
| r_addr_i | input | 11 | Right port word address |
| r_wdata_i | input | 9 | Right port write data |
| r_rdata_o | output | 9 | Right port read data, registered |
| r_busy_n_i | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n_o | output | 1 | Right busy flag, active low |

## Verification
The bench makes each port arrive first in turn, and also makes both arrive together. A design that ignored arrival order would flag the wrong side, and one without a tie-break would flag both sides or neither. It then holds a collision for several cycles after the tie-break rule would favour the other side. A design that re-arbitrates every cycle would move busy across mid-contention. Write-back checks after each collision catch a loser write that leaks into the array, a loser read that gets masked, and a slave-mode device that honours its own decision instead of the busy inputs.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int unsigned NPORT = 2;
  localparam int unsigned P_L   = 0;
  localparam int unsigned P_R   = 1;
endpackage

// File: rtl/dpa_collision_det.sv
module dpa_collision_det
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPORT-1:0]          en_i,
  input  logic [NPORT-1:0][AW-1:0]  addr_i,
  output logic                      hit_o,
  output logic [NPORT-1:0]          held_o
);
  logic [NPORT-1:0]         prev_en_q;
  logic [NPORT-1:0][AW-1:0] prev_addr_q;

  assign hit_o = en_i[P_L] & en_i[P_R] & (addr_i[P_L] == addr_i[P_R]);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_en_q[p]   <= 1'b0;
        prev_addr_q[p] <= '0;
      end else begin
        prev_en_q[p]   <= en_i[p];
        prev_addr_q[p] <= addr_i[p];
      end
    end
    // port sat on this same word last cycle
    assign held_o[p] = prev_en_q[p] & en_i[p] & (prev_addr_q[p] == addr_i[p]);
  end
endmodule

// File: rtl/dpa_winner_arb.sv
module dpa_winner_arb
  import dpa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [NPORT-1:0] held_i,
  output logic [NPORT-1:0] lose_o
);
  logic win_valid_q, win_r_q, pick_r;

  always_comb begin
    if (win_valid_q)                     pick_r = win_r_q;
    else if (held_i[P_R] && !held_i[P_L]) pick_r = 1'b1;
    else                                 pick_r = 1'b0;  // left priority on tie
  end

  assign lose_o[P_L] = rst_ni & hit_i & pick_r;
  assign lose_o[P_R] = rst_ni & hit_i & ~pick_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_q <= 1'b0;
      win_r_q     <= 1'b0;
    end else begin
      win_valid_q <= hit_i;
      win_r_q     <= hit_i & pick_r;
    end
  end
endmodule

// File: rtl/dpa_mem.sv
module dpa_mem
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 9
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPORT-1:0]          we_i,
  input  logic [NPORT-1:0]          re_i,
  input  logic [NPORT-1:0][AW-1:0]  addr_i,
  input  logic [NPORT-1:0][DW-1:0]  wdata_i,
  output logic [NPORT-1:0][DW-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // right first so left lands last on a shared word
  always_ff @(posedge clk_i) begin
    if (we_i[P_R]) mem_q[addr_i[P_R]] <= wdata_i[P_R];
    if (we_i[P_L]) mem_q[addr_i[P_L]] <= wdata_i[P_L];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_o[p] <= '0;
      else if (re_i[p]) rdata_o[p] <= mem_q[addr_i[p]];
    end
  end
endmodule

// File: rtl/dual_port_arbiter.sv
module dual_port_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slave_mode_i,
  input  logic          l_en_i,
  input  logic          l_wr_i,
  input  logic          l_oe_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_wdata_i,
  output logic [DW-1:0] l_rdata_o,
  input  logic          l_busy_n_i,
  output logic          l_busy_n_o,
  input  logic          r_en_i,
  input  logic          r_wr_i,
  input  logic          r_oe_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_wdata_i,
  output logic [DW-1:0] r_rdata_o,
  input  logic          r_busy_n_i,
  output logic          r_busy_n_o
);
  logic [NPORT-1:0]         en, wr, oe, ext_busy_n, lose, inhibit, we, re, held;
  logic [NPORT-1:0][AW-1:0] addr;
  logic [NPORT-1:0][DW-1:0] wdata, rdata;
  logic                     hit;
  logic                     wr_go_l, wr_go_r;

  assign en         = {r_en_i, l_en_i};
  assign wr         = {r_wr_i, l_wr_i};
  assign oe         = {r_oe_i, l_oe_i};
  assign addr       = {r_addr_i, l_addr_i};
  assign wdata      = {r_wdata_i, l_wdata_i};
  assign ext_busy_n = {r_busy_n_i, l_busy_n_i};

  dpa_collision_det #(.AW(AW)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .addr_i (addr),
    .hit_o  (hit),
    .held_o (held)
  );

  dpa_winner_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .held_i (held),
    .lose_o (lose)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_gate
    assign inhibit[p] = slave_mode_i ? ~ext_busy_n[p] : lose[p];
    assign we[p]      = en[p] & wr[p] & ~inhibit[p];
    assign re[p]      = en[p] & oe[p];
  end

  assign wr_go_l = we[P_L];
  assign wr_go_r = we[P_R];

  dpa_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .re_i    (re),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign l_rdata_o  = rdata[P_L];
  assign r_rdata_o  = rdata[P_R];
  // always driven, never released
  assign l_busy_n_o = ~(~slave_mode_i & lose[P_L]);
  assign r_busy_n_o = ~(~slave_mode_i & lose[P_R]);
endmodule

// File: rtl/dpa_chk.sv
module dpa_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          slave_mode_i,
  input logic          l_en_i,
  input logic          r_en_i,
  input logic [AW-1:0] l_addr_i,
  input logic [AW-1:0] r_addr_i,
  input logic          l_busy_n_o,
  input logic          r_busy_n_o,
  input logic          wr_go_l,
  input logic          wr_go_r
);
  logic hit;
  assign hit = l_en_i & r_en_i & (l_addr_i == r_addr_i);

  // R1
  always_comb begin
    if (!rst_ni) rst_idle_chk: assert (l_busy_n_o && r_busy_n_o);
  end

  // R4
  one_loser_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_n_o && !r_busy_n_o));

  // R2
  busy_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && (!l_busy_n_o || !r_busy_n_o)) |-> hit);

  // R4
  hit_has_loser_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && hit) |-> (l_busy_n_o ^ r_busy_n_o));

  // R9
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_mode_i |-> (l_busy_n_o && r_busy_n_o));

  // R5
  hold_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && hit && $past(!slave_mode_i && hit && !l_busy_n_o)) |-> !l_busy_n_o);

  // R5
  hold_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && hit && $past(!slave_mode_i && hit && !r_busy_n_o)) |-> !r_busy_n_o);

  // R7
  loser_no_write_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && !l_busy_n_o) |-> !wr_go_l);

  // R7
  loser_no_write_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && !r_busy_n_o) |-> !wr_go_r);
endmodule

bind dual_port_arbiter dpa_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slave_mode_i (slave_mode_i),
  .l_en_i       (l_en_i),
  .r_en_i       (r_en_i),
  .l_addr_i     (l_addr_i),
  .r_addr_i     (r_addr_i),
  .l_busy_n_o   (l_busy_n_o),
  .r_busy_n_o   (r_busy_n_o),
  .wr_go_l      (wr_go_l),
  .wr_go_r      (wr_go_r)
);

// File: tb/dual_port_arbiter_tb.sv
module dual_port_arbiter_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic slave_mode;
  logic l_en, l_wr, l_oe, l_busy_n_i, r_en, r_wr, r_oe, r_busy_n_i;
  logic [10:0] l_addr, r_addr;
  logic [8:0]  l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_busy_n_o, r_busy_n_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_port_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .slave_mode_i(slave_mode),
    .l_en_i(l_en), .l_wr_i(l_wr), .l_oe_i(l_oe), .l_addr_i(l_addr),
    .l_wdata_i(l_wdata), .l_rdata_o(l_rdata), .l_busy_n_i(l_busy_n_i), .l_busy_n_o(l_busy_n_o),
    .r_en_i(r_en), .r_wr_i(r_wr), .r_oe_i(r_oe), .r_addr_i(r_addr),
    .r_wdata_i(r_wdata), .r_rdata_o(r_rdata), .r_busy_n_i(r_busy_n_i), .r_busy_n_o(r_busy_n_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_l(input logic en, input logic wr, input logic oe,
                       input logic [10:0] a, input logic [8:0] d);
    l_en = en; l_wr = wr; l_oe = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic en, input logic wr, input logic oe,
                       input logic [10:0] a, input logic [8:0] d);
    r_en = en; r_wr = wr; r_oe = oe; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    set_l(0, 0, 0, '0, '0);
    set_r(0, 0, 0, '0, '0);
    step();
  endtask

  task automatic rd_l(input logic [10:0] a, input logic [8:0] exp, input string tag);
    set_l(1, 0, 1, a, '0); set_r(0, 0, 0, '0, '0);
    step(); #1 chk(tag, l_rdata, exp);
  endtask

  task automatic t_reset();
    #1 chk("R1 reset l busy", l_busy_n_o, 1);
    chk("R1 reset r busy", r_busy_n_o, 1);
    step(); rst_ni = 1'b1;
    step(); #1 chk("R1 idle l busy", l_busy_n_o, 1);
    chk("R1 idle r busy", r_busy_n_o, 1);
  endtask

  task automatic t_no_conflict();
    idle();
    set_l(1, 1, 0, 11'h010, 9'h0A1); set_r(1, 1, 0, 11'h011, 9'h1B2);
    #1 chk("R2 distinct l busy", l_busy_n_o, 1);
    chk("R2 distinct r busy", r_busy_n_o, 1);
    step();
    set_l(0, 0, 0, 11'h020, '0); set_r(1, 0, 0, 11'h020, '0);
    #1 chk("R2 one enable r busy", r_busy_n_o, 1);
    step();
    rd_l(11'h010, 9'h0A1, "R10 left write readback");
    set_l(0, 0, 0, '0, '0); set_r(1, 0, 1, 11'h011, '0);
    step(); #1 chk("R10 right write readback", r_rdata, 9'h1B2);
    set_r(1, 0, 0, 11'h010, '0);
    step(); #1 chk("R10 rdata holds", r_rdata, 9'h1B2);
  endtask

  task automatic t_earlier_wins();
    idle();
    set_l(1, 1, 0, 11'h2A0, 9'h055); step();
    set_l(1, 1, 0, 11'h2A0, 9'h066); set_r(1, 1, 0, 11'h2A0, 9'h1AA);
    #1 chk("R3 left earlier r busy", r_busy_n_o, 0);
    chk("R3 left earlier l busy", l_busy_n_o, 1);
    step(); idle();
    rd_l(11'h2A0, 9'h066, "R7 loser write blocked");
    idle();
    set_l(1, 1, 0, 11'h2B0, 9'h033); step();
    set_l(0, 0, 0, '0, '0); set_r(1, 0, 0, 11'h2B0, '0); step();
    set_l(1, 1, 0, 11'h2B0, 9'h0F0);
    #1 chk("R3 right earlier l busy", l_busy_n_o, 0);
    chk("R3 right earlier r busy", r_busy_n_o, 1);
    step(); idle();
    rd_l(11'h2B0, 9'h033, "R7 left loser write blocked");
  endtask

  task automatic t_simul();
    idle();
    set_l(1, 1, 0, 11'h300, 9'h011); set_r(1, 1, 0, 11'h300, 9'h122);
    #1 chk("R4 tie r busy", r_busy_n_o, 0);
    chk("R4 tie l busy", l_busy_n_o, 1);
    step(); idle();
    rd_l(11'h300, 9'h011, "R4 tie winner data");
    idle();
    set_l(1, 0, 1, 11'h301, '0); set_r(1, 0, 1, 11'h301, '0);
    #1 chk("R2 two reads still collide", r_busy_n_o, 0);
    step();
  endtask

  task automatic t_hold_release();
    idle();
    set_r(1, 0, 0, 11'h400, '0); step();
    set_l(1, 0, 0, 11'h400, '0);
    for (int i = 0; i < 3; i++) begin
      #1 chk("R5 winner held l busy", l_busy_n_o, 0);
      chk("R5 winner held r busy", r_busy_n_o, 1);
      step();
    end
    set_r(1, 0, 0, 11'h401, '0);
    #1 chk("R6 addr differ l busy", l_busy_n_o, 1);
    chk("R6 addr differ r busy", r_busy_n_o, 1);
    step();
    set_r(1, 0, 0, 11'h400, '0);
    #1 chk("R3 left parked r busy", r_busy_n_o, 0);
    step();
    set_l(0, 0, 0, 11'h400, '0);
    #1 chk("R6 enable drop r busy", r_busy_n_o, 1);
    step();
  endtask

  task automatic t_loser_read();
    idle();
    set_l(1, 1, 0, 11'h500, 9'h123); step();
    set_l(1, 0, 1, 11'h500, '0); step();
    set_r(1, 0, 1, 11'h500, '0);
    #1 chk("R8 r is loser", r_busy_n_o, 0);
    step(); #1 chk("R8 loser read data", r_rdata, 9'h123);
  endtask

  task automatic t_slave();
    idle();
    slave_mode = 1'b1; l_busy_n_i = 1'b0; r_busy_n_i = 1'b1;
    set_l(1, 1, 0, 11'h600, 9'h001); set_r(1, 1, 0, 11'h600, 9'h1FE);
    #1 chk("R9 slave l busy out", l_busy_n_o, 1);
    chk("R9 slave r busy out", r_busy_n_o, 1);
    step();
    l_busy_n_i = 1'b1;
    set_r(0, 0, 0, '0, '0); set_l(1, 1, 0, 11'h601, 9'h0AA); step();
    l_busy_n_i = 1'b0;
    set_l(1, 1, 0, 11'h601, 9'h155); step();
    l_busy_n_i = 1'b1;
    rd_l(11'h600, 9'h1FE, "R9 slave inhibit-high write lands");
    rd_l(11'h601, 9'h0AA, "R9 slave inhibit-low write blocked");
    slave_mode = 1'b0;
  endtask

  task automatic t_master_ignores_in();
    idle();
    l_busy_n_i = 1'b0; r_busy_n_i = 1'b0;
    set_l(1, 1, 0, 11'h700, 9'h007); step();
    rd_l(11'h700, 9'h007, "R11 busy input ignored in master");
    l_busy_n_i = 1'b1; r_busy_n_i = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    slave_mode = 1'b0; l_busy_n_i = 1'b1; r_busy_n_i = 1'b1;
    set_l(0, 0, 0, '0, '0); set_r(0, 0, 0, '0, '0);
    step();
    t_reset();
    t_no_conflict();
    t_earlier_wins();
    t_simul();
    t_hold_release();
    t_loser_read();
    t_slave();
    t_master_ignores_in();
    idle();
    finish_run();
  end
endmodule